// File: doc/BRIEF.md
# Banked GPIO Register Interface

This block is the register front end of a general-purpose I/O controller with four banks of 32 pins. A word-wide bus reads and writes per-bank registers. These registers hold the output latch, the pin direction, the rising and falling edge enables, two alternate-function words per bank, and a copy of the last value written to the output-set register. Output bits change only through separate write-one-to-set and write-one-to-clear registers. A pin drives its latch bit only when its direction bit marks it as an output.

Pin inputs reach the block already synchronized. A level read returns, for each pin, the latch bit if the pin is an output or the sampled input if it is an input. Every level read also produces a one-cycle notify pulse. Edge detection itself lives in a separate unit. This block gives that unit the enables and the directions, shows that unit's status bits on reads, and hands it a one-cycle clear strobe when software writes ones to an edge-status register. Alternate-function words are storage only and do not control any pad multiplexing.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: While reset is held and after it is released, every register is zero. So `pin_out`, `dir_out`, `rise_en`, `fall_en` and `stat_clr` are all zero, and every pin starts as an input.
- R2: Register kind k for bank b sits at byte offset base(b) + 12*k, where base(b) = 4*b for banks 0 to 2 and base(3) = 0x100. The kinds are: k=0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status. Direction, rising-enable and falling-enable registers read back the last value written and drive `dir_out`, `rise_en` and `fall_en`. In these buses, pin p of bank b is bit 32*b+p.
- R3: The alternate-function low word of bank b is at 0x54 + 8*b and the high word is at 0x58 + 8*b. Both are plain read/write storage.
- R4: Writing the set register ORs the written value into the bank's output latch. Writing the clear register ANDs the latch with the inverse of the value. Reading the set register returns the last value written to it. Reading the clear register returns 0x00007A69.
- R5: Every bit of `pin_out` equals the latch bit ANDed with the direction bit. A pin whose direction bit is 0 never drives 1.
- R6: A level read returns the latch bit where the direction bit is 1, and the `pin_in` bit where the direction bit is 0. The input is sampled in the request cycle.
- R7: An edge-status read returns the bank's 32 bits of `edge_stat`. An edge-status write pulses `stat_clr` for one cycle, carrying the written value on that bank's lanes and zero on all other lanes.
- R8: A read at an offset of 0x200 or above returns zero with `bus_err` low. A write there changes no register and produces no clear strobe.
- R9: A read at an unmapped offset below 0x200 returns zero and sets `bus_err` for one cycle. Unaligned offsets count as unmapped. A write to an unmapped offset changes nothing.
- R10: Each read returns `bus_rdata` with a one-cycle `bus_rvalid` in the cycle after the request. A level read also raises `lvl_notify` in that same cycle, and no other read does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset |
| bus_wdata | input | BANK_W (32) | Write data |
| bus_rdata | output | BANK_W (32) | Read data, registered |
| bus_rvalid | output | 1 | Read data valid pulse |
| bus_err | output | 1 | Unmapped-offset read pulse |
| lvl_notify | output | 1 | Level-register read pulse |
| pin_in | input | NBANK*BANK_W (128) | Synchronized pin inputs |
| pin_out | output | NBANK*BANK_W (128) | Pin outputs, masked by direction |
| dir_out | output | NBANK*BANK_W (128) | Direction bits (1 = output) |
| rise_en | output | NBANK*BANK_W (128) | Rising-edge enables to edge unit |
| fall_en | output | NBANK*BANK_W (128) | Falling-edge enables to edge unit |
| edge_stat | input | NBANK*BANK_W (128) | Status bits from edge unit |
| stat_clr | output | NBANK*BANK_W (128) | One-cycle status-clear strobe |

## Verification
A write takes effect at the clock edge that samples the request. `pin_out`, `dir_out`, the enables and the `stat_clr` strobe are therefore due one cycle after the request, and the strobe is gone one cycle later. Read data, `bus_rvalid`, `bus_err` and `lvl_notify` are registered and also arrive exactly one cycle after the request. The bench drives each request on a falling edge and samples the results on the next falling edge, which lies after exactly one rising edge. For the strobe, it samples again one cycle later to confirm the pulse has ended.

// File: rtl/gpio_regs_pkg.sv
// Package: shared constants, register-kind encoding and offset decode for
// the banked GPIO controller. Assumes exactly four banks in the offset map.
package gpio_regs_pkg;

    localparam int unsigned MAP_BANKS     = 4;
    localparam logic [31:0] BANK3_BASE    = 32'h0000_0100;
    localparam int unsigned KIND_STRIDE   = 12;
    localparam int unsigned BANK_KINDS    = 7;
    localparam logic [31:0] AF_BASE       = 32'h0000_0054;
    localparam int unsigned AF_STRIDE     = 8;
    localparam logic [31:0] WINDOW_END    = 32'h0000_0200;
    localparam logic [31:0] CLR_READ_WORD = 32'h0000_7A69;

    // Kind order fixes the offset of each register (base + 12*kind).
    typedef enum logic [3:0] {
        K_LEVEL = 4'd0,
        K_DIR   = 4'd1,
        K_SET   = 4'd2,
        K_CLR   = 4'd3,
        K_RISE  = 4'd4,
        K_FALL  = 4'd5,
        K_STAT  = 4'd6,
        K_AFLO  = 4'd7,
        K_AFHI  = 4'd8,
        K_NONE  = 4'd15
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [1:0]  bank;
        logic        mapped;
        logic        outside;
    } reg_sel_t;

    // Map a byte offset to register kind and bank.
    function automatic reg_sel_t decode_offset(input logic [31:0] off);
        reg_sel_t s;
        s.kind    = K_NONE;
        s.bank    = 2'd0;
        s.mapped  = 1'b0;
        s.outside = (off >= WINDOW_END);
        if (!s.outside) begin
            for (int b = 0; b < MAP_BANKS; b++) begin
                logic [31:0] base;
                base = (b == MAP_BANKS - 1) ? BANK3_BASE : 32'(4 * b);
                for (int k = 0; k < BANK_KINDS; k++) begin
                    if (off == base + 32'(KIND_STRIDE * k)) begin
                        s.kind   = reg_kind_e'(4'(k));
                        s.bank   = 2'(b);
                        s.mapped = 1'b1;
                    end
                end
                if (off == AF_BASE + 32'(AF_STRIDE * b)) begin
                    s.kind   = K_AFLO;
                    s.bank   = 2'(b);
                    s.mapped = 1'b1;
                end
                if (off == AF_BASE + 32'(AF_STRIDE * b) + 32'd4) begin
                    s.kind   = K_AFHI;
                    s.bank   = 2'(b);
                    s.mapped = 1'b1;
                end
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
// Module: combinational offset decoder. Turns a bus byte offset into a
// register kind, bank index, mapped flag and out-of-window flag.
// Assumes ADDR_W <= 32.
module gpio_addr_dec
    import gpio_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    // Decode the zero-extended offset.
    always_comb begin
        sel = decode_offset(32'(addr));
    end

endmodule

// File: rtl/gpio_bank_regs.sv
// Module: storage for one bank. Holds the output latch, direction, edge
// enables, set-register copy and alternate-function words, and produces the
// one-cycle status-clear strobe. Assumes wr_en is already qualified by bank.
module gpio_bank_regs
    import gpio_regs_pkg::*;
#(
    parameter int unsigned BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_kind_e         kind,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] latch_q,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] rise_q,
    output logic [BANK_W-1:0] fall_q,
    output logic [BANK_W-1:0] setcopy_q,
    output logic [BANK_W-1:0] aflo_q,
    output logic [BANK_W-1:0] afhi_q,
    output logic [BANK_W-1:0] clr_strobe_q
);

    // Output latch: set and clear registers only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q   <= '0;
            setcopy_q <= '0;
        end else if (wr_en && kind == K_SET) begin
            latch_q   <= latch_q | wdata;
            setcopy_q <= wdata;
        end else if (wr_en && kind == K_CLR) begin
            latch_q   <= latch_q & ~wdata;
        end
    end

    // Direction and edge-enable words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_en) begin
            if (kind == K_DIR)  dir_q  <= wdata;
            if (kind == K_RISE) rise_q <= wdata;
            if (kind == K_FALL) fall_q <= wdata;
        end
    end

    // Alternate-function storage words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aflo_q <= '0;
            afhi_q <= '0;
        end else if (wr_en) begin
            if (kind == K_AFLO) aflo_q <= wdata;
            if (kind == K_AFHI) afhi_q <= wdata;
        end
    end

    // One-cycle clear strobe toward the edge-detect unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_strobe_q <= '0;
        end else if (wr_en && kind == K_STAT) begin
            clr_strobe_q <= wdata;
        end else begin
            clr_strobe_q <= '0;
        end
    end

endmodule

// File: rtl/gpio_rd_mux.sv
// Module: combinational read selector. Picks the word for the decoded
// register kind and bank and flags unmapped offsets inside the window.
// Assumes flattened per-bank buses, bank b at bits [b*BANK_W +: BANK_W].
module gpio_rd_mux
    import gpio_regs_pkg::*;
#(
    parameter int unsigned NBANK  = 4,
    parameter int unsigned BANK_W = 32,
    localparam int unsigned PINS  = NBANK * BANK_W
) (
    input  reg_sel_t          sel,
    input  logic [PINS-1:0]   level_v,
    input  logic [PINS-1:0]   dir_v,
    input  logic [PINS-1:0]   setcopy_v,
    input  logic [PINS-1:0]   rise_v,
    input  logic [PINS-1:0]   fall_v,
    input  logic [PINS-1:0]   stat_v,
    input  logic [PINS-1:0]   aflo_v,
    input  logic [PINS-1:0]   afhi_v,
    output logic [BANK_W-1:0] data,
    output logic              err
);

    int unsigned idx;

    // Select the read word for the decoded register.
    always_comb begin
        idx  = int'(sel.bank);
        data = '0;
        if (sel.mapped && idx < NBANK) begin
            case (sel.kind)
                K_LEVEL: data = level_v  [idx*BANK_W +: BANK_W];
                K_DIR:   data = dir_v    [idx*BANK_W +: BANK_W];
                K_SET:   data = setcopy_v[idx*BANK_W +: BANK_W];
                K_CLR:   data = BANK_W'(CLR_READ_WORD);
                K_RISE:  data = rise_v   [idx*BANK_W +: BANK_W];
                K_FALL:  data = fall_v   [idx*BANK_W +: BANK_W];
                K_STAT:  data = stat_v   [idx*BANK_W +: BANK_W];
                K_AFLO:  data = aflo_v   [idx*BANK_W +: BANK_W];
                K_AFHI:  data = afhi_v   [idx*BANK_W +: BANK_W];
                default: data = '0;
            endcase
        end
    end

    // Unmapped offsets below the window end are errors.
    always_comb begin
        err = !sel.outside && !sel.mapped;
    end

endmodule

// File: rtl/banked_gpio_ctrl.sv
// Module: top of the banked GPIO register interface. Decodes bus accesses,
// holds per-bank registers, drives direction-masked outputs, and returns
// registered read data one cycle after a read request.
// Assumes pin_in is already synchronized and NBANK matches the 4-bank map.
module banked_gpio_ctrl
    import gpio_regs_pkg::*;
#(
    parameter int unsigned NBANK  = 4,
    parameter int unsigned BANK_W = 32,
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned PINS  = NBANK * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    output logic              lvl_notify,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   dir_out,
    output logic [PINS-1:0]   rise_en,
    output logic [PINS-1:0]   fall_en,
    input  logic [PINS-1:0]   edge_stat,
    output logic [PINS-1:0]   stat_clr
);

    reg_sel_t          sel;
    logic [PINS-1:0]   latch_v;
    logic [PINS-1:0]   setcopy_v;
    logic [PINS-1:0]   aflo_v;
    logic [PINS-1:0]   afhi_v;
    logic [PINS-1:0]   level_v;
    logic [BANK_W-1:0] rd_word;
    logic              rd_err;
    logic              is_read;

    gpio_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic bank_wr;

        // Qualify the write with this bank.
        always_comb begin
            bank_wr = bus_req && bus_we && sel.mapped && (int'(sel.bank) == b);
        end

        gpio_bank_regs #(.BANK_W(BANK_W)) regs_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (bank_wr),
            .kind         (sel.kind),
            .wdata        (bus_wdata),
            .latch_q      (latch_v  [b*BANK_W +: BANK_W]),
            .dir_q        (dir_out  [b*BANK_W +: BANK_W]),
            .rise_q       (rise_en  [b*BANK_W +: BANK_W]),
            .fall_q       (fall_en  [b*BANK_W +: BANK_W]),
            .setcopy_q    (setcopy_v[b*BANK_W +: BANK_W]),
            .aflo_q       (aflo_v   [b*BANK_W +: BANK_W]),
            .afhi_q       (afhi_v   [b*BANK_W +: BANK_W]),
            .clr_strobe_q (stat_clr [b*BANK_W +: BANK_W])
        );
    end

    // Pin drive and level view: latch for outputs, input for the rest.
    always_comb begin
        pin_out = latch_v & dir_out;
        level_v = pin_out | (pin_in & ~dir_out);
        is_read = bus_req && !bus_we;
    end

    gpio_rd_mux #(.NBANK(NBANK), .BANK_W(BANK_W)) mux_i (
        .sel       (sel),
        .level_v   (level_v),
        .dir_v     (dir_out),
        .setcopy_v (setcopy_v),
        .rise_v    (rise_en),
        .fall_v    (fall_en),
        .stat_v    (edge_stat),
        .aflo_v    (aflo_v),
        .afhi_v    (afhi_v),
        .data      (rd_word),
        .err       (rd_err)
    );

    // Register read data and the one-cycle read pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            bus_err    <= 1'b0;
            lvl_notify <= 1'b0;
        end else begin
            bus_rvalid <= is_read;
            bus_err    <= is_read && rd_err;
            lvl_notify <= is_read && sel.mapped && sel.kind == K_LEVEL;
            if (is_read) begin
                bus_rdata <= rd_word;
            end
        end
    end

endmodule

// File: rtl/gpio_ctrl_chk.sv
// Module: assertion checker for banked_gpio_ctrl, attached with bind.
// Assumes synchronous active-low reset held across the first clock edge.
module gpio_ctrl_chk #(
    parameter int unsigned NBANK  = 4,
    parameter int unsigned BANK_W = 32,
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned PINS  = NBANK * BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BANK_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              bus_err,
    input logic              lvl_notify,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   dir_out,
    input logic [PINS-1:0]   rise_en,
    input logic [PINS-1:0]   fall_en,
    input logic [PINS-1:0]   stat_clr
);

    logic high_off;

    // Flag offsets beyond the register window.
    always_comb begin
        high_off = 32'(bus_addr) >= 32'h200;
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && dir_out == '0 && rise_en == '0
                    && fall_en == '0 && stat_clr == '0));

    assert_out_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~dir_out) == '0);

    assert_clr_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr != '0) |-> $past(bus_req && bus_we));

    assert_high_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && high_off) |=> (bus_rdata == '0 && !bus_err && !lvl_notify));

    assert_high_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && high_off) |=> ($stable(dir_out) && $stable(pin_out)
                                             && stat_clr == '0));

    assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rvalid && bus_rdata == '0 && !lvl_notify));

    assert_rvalid_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    assert_rvalid_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    assert_notify_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_notify |-> bus_rvalid);

endmodule

bind banked_gpio_ctrl gpio_ctrl_chk #(
    .NBANK  (NBANK),
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .bus_err    (bus_err),
    .lvl_notify (lvl_notify),
    .pin_out    (pin_out),
    .dir_out    (dir_out),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .stat_clr   (stat_clr)
);

// File: tb/banked_gpio_ctrl_tb_top.sv
// Bench: directed scenarios for banked_gpio_ctrl, one task each. Inputs
// change on falling edges; results are sampled one falling edge later.
module banked_gpio_ctrl_tb_top;

    localparam int unsigned NB   = 4;
    localparam int unsigned BW   = 32;
    localparam int unsigned AW   = 12;
    localparam int unsigned NPIN = NB * BW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_req = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [BW-1:0]   bus_wdata = '0;
    logic [BW-1:0]   bus_rdata;
    logic            bus_rvalid;
    logic            bus_err;
    logic            lvl_notify;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] pin_out;
    logic [NPIN-1:0] dir_out;
    logic [NPIN-1:0] rise_en;
    logic [NPIN-1:0] fall_en;
    logic [NPIN-1:0] edge_stat = '0;
    logic [NPIN-1:0] stat_clr;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    logic [BW-1:0] rd_data;
    logic          rd_err;
    logic          rd_note;
    logic          rd_valid;

    always #10 clk = ~clk;

    banked_gpio_ctrl #(.NBANK(NB), .BANK_W(BW), .ADDR_W(AW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .bus_err    (bus_err),
        .lvl_notify (lvl_notify),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .dir_out    (dir_out),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .edge_stat  (edge_stat),
        .stat_clr   (stat_clr)
    );

    function automatic logic [31:0] base_of(input int b);
        return (b == 3) ? 32'h100 : 32'(4 * b);
    endfunction

    function automatic logic [AW-1:0] off_of(input int b, input int k);
        return AW'(base_of(b) + 32'(12 * k));
    endfunction

    task automatic check(input string tag, input logic [BW-1:0] act,
                         input logic [BW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [BW-1:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        rd_data = bus_rdata; rd_err = bus_err;
        rd_note = lvl_notify; rd_valid = bus_rvalid;
    endtask

    task automatic t_reset();
        check("R1 pin_out lo", pin_out[31:0], '0);
        check("R1 dir_out hi", dir_out[127:96], '0);
        check("R1 rise_en", rise_en[63:32] | fall_en[95:64], '0);
        check("R1 stat_clr", stat_clr[31:0], '0);
        bus_read(off_of(3, 1));
        check("R1 dir bank3 read", rd_data, '0);
        bus_read(AW'(32'h70));
        check("R1 af hi bank3 read", rd_data, '0);
    endtask

    task automatic t_map();
        for (int b = 0; b < 4; b++) begin
            bus_write(off_of(b, 1), 32'hD100_0000 | 32'(b));
            bus_write(off_of(b, 4), 32'hE200_0000 | 32'(b));
            bus_write(off_of(b, 5), 32'hF300_0000 | 32'(b));
            bus_write(AW'(32'h54 + 32'(8 * b)), 32'h4A00_0000 | 32'(b));
            bus_write(AW'(32'h58 + 32'(8 * b)), 32'h5B00_0000 | 32'(b));
        end
        for (int b = 0; b < 4; b++) begin
            bus_read(off_of(b, 1));
            check("R2 dir readback", rd_data, 32'hD100_0000 | 32'(b));
            bus_read(off_of(b, 4));
            check("R2 rise readback", rd_data, 32'hE200_0000 | 32'(b));
            bus_read(off_of(b, 5));
            check("R2 fall readback", rd_data, 32'hF300_0000 | 32'(b));
            bus_read(AW'(32'h54 + 32'(8 * b)));
            check("R3 af low readback", rd_data, 32'h4A00_0000 | 32'(b));
            bus_read(AW'(32'h58 + 32'(8 * b)));
            check("R3 af high readback", rd_data, 32'h5B00_0000 | 32'(b));
        end
        check("R2 dir_out bank2 lanes", dir_out[95:64], 32'hD100_0002);
        check("R2 rise_en bank3 lanes", rise_en[127:96], 32'hE200_0003);
        check("R2 fall_en bank1 lanes", fall_en[63:32], 32'hF300_0001);
    endtask

    task automatic t_set_clear();
        bus_write(off_of(1, 1), 32'hFFFF_FFFF);
        bus_write(off_of(1, 2), 32'hF0F0_0000);
        bus_write(off_of(1, 2), 32'h0000_000C);
        check("R4 set ORs", pin_out[63:32], 32'hF0F0_000C);
        bus_write(off_of(1, 3), 32'h00F0_0004);
        check("R4 clear ANDs inverse", pin_out[63:32], 32'hF000_0008);
        bus_read(off_of(1, 2));
        check("R4 set readback", rd_data, 32'h0000_000C);
        bus_read(off_of(1, 3));
        check("R4 clear read constant", rd_data, 32'h0000_7A69);
        check("R4 other bank untouched", pin_out[31:0], '0);
    endtask

    task automatic t_mask();
        bus_write(off_of(0, 1), 32'h0000_FFFF);
        bus_write(off_of(0, 2), 32'hFFFF_FFFF);
        check("R5 output masked", pin_out[31:0], 32'h0000_FFFF);
        bus_write(off_of(0, 1), 32'hFF00_0000);
        check("R5 mask follows dir", pin_out[31:0], 32'hFF00_0000);
        bus_write(off_of(0, 1), 32'h0000_FFFF);
    endtask

    task automatic t_level();
        pin_in[31:0] = 32'hA5A5_A5A5;
        pin_in[127:96] = 32'h1234_5678;
        bus_read(off_of(0, 0));
        check("R6 level mix bank0", rd_data, 32'hA5A5_FFFF);
        check("R10 notify on level read", 32'(rd_note), 32'd1);
        check("R10 rvalid on read", 32'(rd_valid), 32'd1);
        bus_write(off_of(3, 1), 32'h0000_0000);
        bus_read(off_of(3, 0));
        check("R6 level bank3 inputs", rd_data, 32'h1234_5678);
        bus_read(off_of(0, 1));
        check("R10 no notify on dir read", 32'(rd_note), 32'd0);
        @(negedge clk);
        check("R10 rvalid ends", 32'(bus_rvalid), 32'd0);
    endtask

    task automatic t_status();
        edge_stat[127:96] = 32'hCAFE_0001;
        edge_stat[63:32]  = 32'h0BAD_F00D;
        bus_read(off_of(3, 6));
        check("R7 status read bank3", rd_data, 32'hCAFE_0001);
        bus_read(off_of(1, 6));
        check("R7 status read bank1", rd_data, 32'h0BAD_F00D);
        bus_write(off_of(1, 6), 32'h0000_00F1);
        check("R7 strobe bank1 lanes", stat_clr[63:32], 32'h0000_00F1);
        check("R7 strobe other lanes", stat_clr[31:0] | stat_clr[95:64] | stat_clr[127:96], '0);
        @(negedge clk);
        check("R7 strobe one cycle", stat_clr[63:32], '0);
    endtask

    task automatic t_high();
        bus_read(AW'(32'h200));
        check("R8 high read zero", rd_data, '0);
        check("R8 high read no err", 32'(rd_err), 32'd0);
        bus_write(AW'(32'h30C), 32'hFFFF_FFFF);
        check("R8 high write ignored dir", dir_out[127:96], '0);
        bus_write(AW'(32'h318), 32'hFFFF_FFFF);
        check("R8 high write ignored latch", pin_out[31:0], 32'h0000_FFFF);
        check("R8 high write no strobe", stat_clr[31:0], '0);
    endtask

    task automatic t_unmapped();
        bus_read(AW'(32'h0F0));
        check("R9 unmapped read zero", rd_data, '0);
        check("R9 unmapped err", 32'(rd_err), 32'd1);
        bus_read(AW'(32'h002));
        check("R9 unaligned err", 32'(rd_err), 32'd1);
        bus_write(AW'(32'h00E), 32'h0000_0000);
        check("R9 unaligned write ignored", dir_out[31:0], 32'h0000_FFFF);
        bus_read(AW'(32'h14C));
        check("R9 past bank3 err", 32'(rd_err), 32'd1);
        bus_read(off_of(2, 1));
        check("R9 err clears on mapped read", 32'(rd_err), 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_set_clear();
        t_mask();
        t_level();
        t_status();
        t_high();
        t_unmapped();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule